// File: doc/BRIEF.md
# Programmed-I/O Cycle Strobe Timer

This block times register and data transfers made by programmed I/O on a parallel disk interface that carries two channels with two drives each. Every drive has three timing values of its own, held in two packed configuration words: how long the address must settle before the strobe, how long the strobe stays low, and how long the bus must rest before the next transfer. All three are kept as the count minus one, so a field of zero means one clock.

A requester presents a drive number and a direction and holds `req_valid` until `req_ready` is high. On the accepting clock edge, the timer takes the chosen drive's fields and walks through four phases. In address setup, the address is valid and both strobes are high. In the active phase, the read or the write strobe is low. In recovery, both strobes are high again. A one-clock `done` pulse follows, and the timer then returns to idle. For reads, the bus data is captured on the clock edge that ends the active phase.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, `rd_strobe_n` and `wr_strobe_n` are 1, `addr_valid` and `done` are 0, `req_ready` is 1 and `rd_data` is 0.
- R2: Drive d (0..3) takes its timing byte from `timing_word` bits [31-8d : 24-8d]. The upper nibble of that byte is the active width field and the lower nibble is the recovery field. Its setup field is `setup_word` bits [7-2d : 6-2d]. The transfer reports the accepted drive on `cyc_drive`.
- R3: The address-setup phase lasts setup field + 1 clocks (1 to 4). During it, `addr_valid` is 1 and both strobes are 1.
- R4: The active phase lasts active field + 1 clocks (1 to 16). `rd_strobe_n` is low for a read (`req_write`=0) and `wr_strobe_n` is low for a write (`req_write`=1). The other strobe stays 1, and the two strobes are never low together.
- R5: The recovery phase lasts recovery field + 1 clocks (1 to 16). During it, `addr_valid` is 1 and both strobes are 1.
- R6: `done` is high for exactly one clock right after recovery, with `addr_valid` 0. On the next clock, `req_ready` is 1.
- R7: `req_ready` is 0 from the accepting edge until `done` has ended. A request held high during that time is not accepted and does not disturb the transfer in flight. It starts once the timer is idle.
- R8: The timing fields are sampled on the accepting edge. A change to `timing_word` or `setup_word` during a transfer affects only later transfers.
- R9: On a read, `rd_data` takes the value `bus_rd_data` had on the clock edge that ends the active phase. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_word | input | 32 | Per-drive active and recovery fields, drive 0 in the top byte |
| setup_word | input | 8 | Per-drive address-setup fields, drive 0 in the top two bits |
| req_valid | input | 1 | Transfer request, held until accepted |
| req_drive | input | 2 | Drive number for the request |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| req_ready | output | 1 | Timer is idle and accepts a request this clock |
| bus_rd_data | input | 16 | Data on the disk bus during a read |
| rd_data | output | 16 | Data captured by the last read |
| addr_valid | output | 1 | Address phase in progress (setup, active, recovery) |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| cyc_drive | output | 2 | Drive of the transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |

## Verification
The bench builds the timer with its default parameters: four drives, 4-bit active and recovery fields, 2-bit setup fields and a 16-bit data path. At these widths, a test can write every field at both ends of its range, so a bench that runs fewer than 200,000 clocks covers the 1-clock and 16-clock strobe and recovery phases and the 1-clock and 4-clock setup phases. Each drive gets a different pattern, so a byte or nibble picked from the wrong slot shows up as a wrong phase length.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_RECOV  = 3'd3,
      PH_DONE   = 3'd4
   } pio_phase_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
   parameter int NUM_DRIVES = 4,
   parameter int ACT_W      = 4,
   parameter int REC_W      = 4,
   parameter int SET_W      = 2,
   parameter int DRV_W      = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_DRIVES*(ACT_W+REC_W)-1:0] timing_word,
   input  logic [NUM_DRIVES*SET_W-1:0]         setup_word,
   input  logic [DRV_W-1:0]                  sel_drive,
   input  logic                              capture,
   output logic [SET_W-1:0]                  setup_now,
   output logic [ACT_W-1:0]                  act_lat,
   output logic [REC_W-1:0]                  rec_lat
);

   localparam int SLOT_W = ACT_W + REC_W;

   logic [ACT_W-1:0] act_f [NUM_DRIVES];
   logic [REC_W-1:0] rec_f [NUM_DRIVES];
   logic [SET_W-1:0] set_f [NUM_DRIVES];
   logic [ACT_W-1:0] act_now;
   logic [REC_W-1:0] rec_now;

   // Slot 0 sits at the most significant end of each word.
   for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_slot
      assign act_f[i] = timing_word[(NUM_DRIVES-i)*SLOT_W-1 -: ACT_W];
      assign rec_f[i] = timing_word[(NUM_DRIVES-i)*SLOT_W-ACT_W-1 -: REC_W];
      assign set_f[i] = setup_word[(NUM_DRIVES-i)*SET_W-1 -: SET_W];
   end

   if (NUM_DRIVES == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel_drive;
      assign act_now    = act_f[0];
      assign rec_now    = rec_f[0];
      assign setup_now  = set_f[0];
   end else begin : g_mux
      always_comb begin
         act_now   = '0;
         rec_now   = '0;
         setup_now = '0;
         for (int k = 0; k < NUM_DRIVES; k++) begin
            if (int'(sel_drive) == k) begin
               act_now   = act_f[k];
               rec_now   = rec_f[k];
               setup_now = set_f[k];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_lat <= '0;
         rec_lat <= '0;
      end else if (capture) begin
         act_lat <= act_now;
         rec_lat <= rec_now;
      end
   end

   // R8
   held_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> ($stable(act_lat) && $stable(rec_lat)))
      else $error("latched fields moved without a capture");

endmodule

// File: rtl/pio_phase_counter.sv
module pio_phase_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_zero = (cnt_q == '0);

   // R3 R4 R5: each clock without a load moves the count one step toward zero
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !cnt_zero) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("phase counter skipped a step");

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
   import pio_timer_pkg::*;
#(
   parameter int DRV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [DRV_W-1:0] req_drive,
   input  logic             req_write,
   input  logic             cnt_zero,
   output pio_phase_e       phase,
   output logic             accept,
   output logic             load,
   output pio_phase_e       load_sel,
   output logic [DRV_W-1:0] cyc_drive,
   output logic             cyc_write
);

   pio_phase_e nxt;

   assign accept = (phase == PH_IDLE) && req_valid;

   always_comb begin
      nxt = phase;
      case (phase)
         PH_IDLE:   if (req_valid) nxt = PH_SETUP;
         PH_SETUP:  if (cnt_zero)  nxt = PH_ACTIVE;
         PH_ACTIVE: if (cnt_zero)  nxt = PH_RECOV;
         PH_RECOV:  if (cnt_zero)  nxt = PH_DONE;
         PH_DONE:                  nxt = PH_IDLE;
         default:                  nxt = PH_IDLE;
      endcase
   end

   assign load     = accept
                   || ((phase == PH_SETUP)  && cnt_zero)
                   || ((phase == PH_ACTIVE) && cnt_zero);
   assign load_sel = nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cyc_drive <= '0;
         cyc_write <= 1'b0;
      end else begin
         phase <= nxt;
         if (accept) begin
            cyc_drive <= req_drive;
            cyc_write <= req_write;
         end
      end
   end

   // R6
   done_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE))
      else $error("done phase lasted more than one clock");

   // R7
   busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && (phase != PH_DONE)) |=> (phase != PH_SETUP) || ($past(phase) == PH_SETUP))
      else $error("transfer restarted while busy");

   // R7
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(cyc_drive) && $stable(cyc_write))
      else $error("transfer attributes changed mid-transfer");

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
   import pio_timer_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int ACT_W      = 4,
   parameter int REC_W      = 4,
   parameter int SET_W      = 2,
   parameter int DATA_W     = 16,
   localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
   localparam int SLOT_W    = ACT_W + REC_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_DRIVES*SLOT_W-1:0] timing_word,
   input  logic [NUM_DRIVES*SET_W-1:0]  setup_word,
   input  logic                         req_valid,
   input  logic [DRV_W-1:0]             req_drive,
   input  logic                         req_write,
   output logic                         req_ready,
   input  logic [DATA_W-1:0]            bus_rd_data,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         addr_valid,
   output logic                         rd_strobe_n,
   output logic                         wr_strobe_n,
   output logic [DRV_W-1:0]             cyc_drive,
   output logic                         done
);

   localparam int CNT_W = int'(max3(ACT_W, REC_W, SET_W));

   if (NUM_DRIVES < 1) begin : g_bad_drives
      $error("NUM_DRIVES must be at least 1");
   end
   if (ACT_W < 1 || REC_W < 1 || SET_W < 1) begin : g_bad_fields
      $error("timing field widths must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   pio_phase_e       phase;
   pio_phase_e       load_sel;
   logic             accept;
   logic             load;
   logic             cnt_zero;
   logic             cyc_write;
   logic [SET_W-1:0] setup_now;
   logic [ACT_W-1:0] act_lat;
   logic [REC_W-1:0] rec_lat;
   logic [CNT_W-1:0] load_val;

   pio_timing_select #(
      .NUM_DRIVES (NUM_DRIVES),
      .ACT_W      (ACT_W),
      .REC_W      (REC_W),
      .SET_W      (SET_W),
      .DRV_W      (DRV_W)
   ) u_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .timing_word (timing_word),
      .setup_word  (setup_word),
      .sel_drive   (req_drive),
      .capture     (accept),
      .setup_now   (setup_now),
      .act_lat     (act_lat),
      .rec_lat     (rec_lat)
   );

   pio_strobe_seq #(
      .DRV_W (DRV_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_drive (req_drive),
      .req_write (req_write),
      .cnt_zero  (cnt_zero),
      .phase     (phase),
      .accept    (accept),
      .load      (load),
      .load_sel  (load_sel),
      .cyc_drive (cyc_drive),
      .cyc_write (cyc_write)
   );

   always_comb begin
      case (load_sel)
         PH_SETUP:  load_val = CNT_W'(setup_now);
         PH_ACTIVE: load_val = CNT_W'(act_lat);
         PH_RECOV:  load_val = CNT_W'(rec_lat);
         default:   load_val = '0;
      endcase
   end

   pio_phase_counter #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .cnt_zero (cnt_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if ((phase == PH_ACTIVE) && cnt_zero && !cyc_write)
         rd_data <= bus_rd_data;
   end

   assign req_ready   = (phase == PH_IDLE);
   assign addr_valid  = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_RECOV);
   assign rd_strobe_n = !((phase == PH_ACTIVE) && !cyc_write);
   assign wr_strobe_n = !((phase == PH_ACTIVE) &&  cyc_write);
   assign done        = (phase == PH_DONE);

   // R4
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe_n || wr_strobe_n)
      else $error("both strobes low");

   // R6
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready)
      else $error("not ready after done");

   // R9
   rd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe_n |=> $stable(rd_data))
      else $error("read data changed outside a read strobe");

   // R5
   recov_follows_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_strobe_n & wr_strobe_n) |-> addr_valid)
      else $error("strobe ended without a recovery phase");

endmodule

// File: tb/pio_cycle_timer_bench.sv
module pio_cycle_timer_bench;

   typedef struct {
      int drive;
      bit write;
      int s_len;
      int a_len;
      int r_len;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tw = '0;
   logic [7:0]  sw = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_drive = '0;
   logic        req_write = 1'b0;
   logic        req_ready;
   logic [15:0] bus_word = 16'h1000;
   logic [15:0] rd_data;
   logic        addr_valid, rd_strobe_n, wr_strobe_n, done;
   logic [1:0]  cyc_drive;

   int   checks = 0;
   int   failures = 0;
   bit   finished = 0;
   exp_t exp_q[$];

   always #5 clk = ~clk;

   pio_cycle_timer u_pio_cycle_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .timing_word (tw),
      .setup_word  (sw),
      .req_valid   (req_valid),
      .req_drive   (req_drive),
      .req_write   (req_write),
      .req_ready   (req_ready),
      .bus_rd_data (bus_word),
      .rd_data     (rd_data),
      .addr_valid  (addr_valid),
      .rd_strobe_n (rd_strobe_n),
      .wr_strobe_n (wr_strobe_n),
      .cyc_drive   (cyc_drive),
      .done        (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // bus data moves every clock so a capture on the wrong edge is visible
   initial begin
      forever begin
         @(posedge clk);
         bus_word <= bus_word + 16'h0123;
      end
   end

   // driver: R2 field mapping computed from the words at acceptance
   task automatic issue(input int d, input bit w);
      exp_t e;
      logic [7:0] slot;
      logic [1:0] sf;
      @(negedge clk);
      req_valid = 1'b1;
      req_drive = 2'(d);
      req_write = w;
      while (!req_ready) @(negedge clk);
      slot    = 8'(tw >> (8 * (3 - d)));
      sf      = 2'(sw >> (2 * (3 - d)));
      e.drive = d;
      e.write = w;
      e.a_len = int'(slot[7:4]) + 1;
      e.r_len = int'(slot[3:0]) + 1;
      e.s_len = int'(sf) + 1;
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor
   initial begin
      bit in_cyc = 0;
      bit prev_done = 0;
      bit saw_rd = 0, saw_wr = 0;
      int s_cnt = 0, a_cnt = 0, r_cnt = 0;
      int obs_drive = 0;
      logic [15:0] last_bus = '0;
      logic [15:0] model_rd = '0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_done)
               chk(!done && req_ready, "R6", "done width / ready after done",
                   int'({done, req_ready}), 1);
            prev_done = done;
            if (addr_valid) begin
               if (!in_cyc) begin
                  in_cyc = 1; s_cnt = 0; a_cnt = 0; r_cnt = 0;
                  saw_rd = 0; saw_wr = 0; obs_drive = int'(cyc_drive);
               end
               if (req_ready)
                  chk(0, "R7", "ready high while busy", 1, 0);
               if (!rd_strobe_n && !wr_strobe_n)
                  chk(0, "R4", "both strobes low", 0, 1);
               if (!rd_strobe_n || !wr_strobe_n) begin
                  a_cnt++;
                  if (!rd_strobe_n) saw_rd = 1;
                  if (!wr_strobe_n) saw_wr = 1;
                  last_bus = bus_word;
               end else if (a_cnt == 0) s_cnt++;
               else r_cnt++;
            end
            if (done) begin
               if (addr_valid) chk(0, "R6", "addr_valid during done", 1, 0);
               if (exp_q.size() == 0) begin
                  chk(0, "R7", "unexpected transfer", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(obs_drive == e.drive, "R2", "cyc_drive", obs_drive, e.drive);
                  chk(s_cnt == e.s_len, "R3", "setup clocks", s_cnt, e.s_len);
                  chk(a_cnt == e.a_len, "R4", "active clocks", a_cnt, e.a_len);
                  chk(r_cnt == e.r_len, "R5", "recovery clocks", r_cnt, e.r_len);
                  chk(saw_wr == e.write && saw_rd == !e.write, "R4", "strobe direction",
                      int'({saw_rd, saw_wr}), e.write ? 1 : 2);
                  if (!e.write) model_rd = last_bus;
                  chk(rd_data == model_rd, "R9", "rd_data", int'(rd_data), int'(model_rd));
               end
               in_cyc = 0;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   task automatic wait_empty();
      while (exp_q.size() != 0 || !req_ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_strobe_n == 1, "R1", "rd_strobe_n", int'(rd_strobe_n), 1);
      chk(wr_strobe_n == 1, "R1", "wr_strobe_n", int'(wr_strobe_n), 1);
      chk(addr_valid == 0, "R1", "addr_valid", int'(addr_valid), 0);
      chk(done == 0, "R1", "done", int'(done), 0);
      chk(req_ready == 1, "R1", "req_ready", int'(req_ready), 1);
      chk(rd_data == 0, "R1", "rd_data", int'(rd_data), 0);

      // R2 distinct slot patterns; drive 2: active 1 / recovery 16, drive 3: active 16 / recovery 1
      tw = {8'h21, 8'h53, 8'h0F, 8'hF0};
      sw = {2'd1, 2'd3, 2'd0, 2'd2};
      // R7 back-to-back requests are held while busy
      issue(0, 0);
      issue(1, 1);
      issue(2, 0);
      issue(3, 0);
      issue(3, 1);
      issue(0, 1);
      wait_empty();

      // R8 field change during a transfer applies to the next one only
      issue(1, 0);
      @(negedge clk);
      tw[23:16] = 8'hA2;
      sw[5:4]   = 2'd0;
      issue(1, 0);
      wait_empty();

      // R9 write leaves rd_data, then read picks fresh bus data
      issue(2, 1);
      issue(0, 0);
      wait_empty();

      chk(exp_q.size() == 0, "R7", "pending transfers", exp_q.size(), 0);
      chk(req_ready && !addr_valid, "R6", "idle at end", int'({req_ready, addr_valid}), 2);
      summary();
   end

endmodule